// File: doc/BRIEF.md
# Scalar Binary64-to-Binary32 Converter with Vector Merge

This block narrows one IEEE-754 double-precision number to single precision and writes the 32-bit result into the lowest element of a wide vector destination. The value to convert is taken from the low 64 bits of a source vector. The caller selects a rounding direction through a global 2-bit field. In the masked merge style, a per-operation override may replace that field. The block reports the standard exception flags for every conversion.

Around the conversion sits a merge stage with three policies. The first keeps the rest of the old destination. The second copies bits 127:32 from a pass-through vector and clears everything above bit 127. The third works like the second, but gates the low element with a one-bit writemask that either preserves the old value or zeroes it. The datapath is combinational, and a single valid-qualified register stage follows it, so a result appears one cycle after its operands.

Top module: `d2s_convert_top`

## Requirements
- R1: The operand is `src_vec[63:0]`. Results that fit exactly (normal values such as 1.0, -2.5, the smallest binary32 normal and the largest finite binary32) appear in `dst_out[31:0]` with all flags clear. Flag bits are: bit 0 invalid, bit 1 overflow, bit 2 underflow, bit 3 inexact.
- R2: The rounding field encodes 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. The inexact flag is set whenever bits are discarded.
- R3: Overflow before or after rounding sets the overflow and inexact flags. The result is signed infinity under nearest-even, or under a direction that points away from zero for that sign. Otherwise the result is the signed largest finite value 0x7F7FFFFF.
- R4: Results below 2^-126 before rounding are denormalized with correct rounding. Underflow is set when such a tiny result is inexact. Binary64 denormal inputs become signed zero or the smallest signed binary32 denormal, according to the rounding direction.
- R5: A NaN input yields exponent 0xFF, quiet bit 22 set, the same sign, and fraction bits 21:0 taken from input fraction bits 50:29. A signaling input (input fraction bit 51 clear) also sets invalid.
- R6: Signed zeros and signed infinities convert exactly with no flags.
- R7: With `merge_sel` = 00, `dst_out` bits above 31 equal `old_dst`.
- R8: With `merge_sel` = 01 (and the reserved value 11), `dst_out[127:32]` equals `pass_vec[127:32]` and all bits above 127 are zero.
- R9: With `merge_sel` = 10, the upper bits follow R8. When `wmask` is set, bits 31:0 take the result. When `wmask` is clear, bits 31:0 keep `old_dst[31:0]`, or are zero when `zeroing` is set, and all flags read zero.
- R10: Only with `merge_sel` = 10 and `rnd_ovr_en` set does `rnd_ovr` replace `rnd_global`. In every other case the override has no effect.
- R11: `out_valid` equals `in_valid` one cycle earlier. `dst_out` and `flags` change only on a cycle after `in_valid` was high. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| src_vec | input | VEC_W | Vector whose low 64 bits are converted |
| pass_vec | input | VEC_W | Vector supplying bits 127:32 in the copy and masked styles |
| old_dst | input | VEC_W | Previous destination contents |
| rnd_global | input | 2 | Global rounding direction |
| rnd_ovr_en | input | 1 | Enables the per-operation rounding override |
| rnd_ovr | input | 2 | Per-operation rounding direction |
| merge_sel | input | 2 | Merge policy: 00 keep, 01 copy, 10 masked, 11 as copy |
| wmask | input | 1 | Write enable for the low element in masked style |
| zeroing | input | 1 | Zero the low element when masked off |
| out_valid | output | 1 | Registered result valid |
| dst_out | output | VEC_W | Merged destination vector |
| flags | output | 4 | {inexact, underflow, overflow, invalid} |

## Verification
The conversion is driven with exact normal values and with halfway and above-halfway fractions under all four rounding directions, which separates round-to-even from truncation and from the two directed modes. Inputs just below, at and above the binary32 overflow threshold, of both signs, show the choice between infinity and the largest finite value. Values at the smallest denormal, at half of it, and binary64 denormals expose the shift, sticky and underflow logic. Quiet and signaling NaNs check the payload and the invalid flag. Each merge style is then run with distinct old and pass-through patterns, and the masked style is run with every mask and zeroing combination and with the override both on and off, so that bits coming from the wrong vector stand out.

// File: rtl/d2s_pkg.sv
package d2s_pkg;

  typedef enum logic [1:0] {
    RND_NE = 2'b00,
    RND_DN = 2'b01,
    RND_UP = 2'b10,
    RND_TZ = 2'b11
  } rnd_mode_e;

  typedef enum logic [1:0] {
    MRG_KEEP = 2'b00,
    MRG_COPY = 2'b01,
    MRG_MASK = 2'b10,
    MRG_RSVD = 2'b11
  } merge_e;

  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic invalid;
  } fp_flags_t;

  localparam int unsigned D_EXP_W    = 11;
  localparam int unsigned D_FRAC_W   = 52;
  localparam int unsigned S_EXP_W    = 8;
  localparam int unsigned S_FRAC_W   = 23;
  localparam int unsigned BIAS_DELTA = 896;   // 1023 - 127
  localparam int unsigned S_EXP_MAX  = 254;
  localparam int unsigned RES_W      = 32;
  localparam int unsigned LANE_W     = 128;
  localparam int unsigned SRC_W      = 64;

endpackage

// File: rtl/d2s_round_core.sv
module d2s_round_core
  import d2s_pkg::*;
(
  input  logic [SRC_W-1:0] src,
  input  rnd_mode_e        mode,
  output logic [RES_W-1:0] res,
  output fp_flags_t        flg
);

  localparam int unsigned SIG_W   = D_FRAC_W + 1;          // 53
  localparam int unsigned PAD_W   = 32;
  localparam int unsigned WIDE_W  = SIG_W + PAD_W;         // 85
  localparam int unsigned KEEP_W  = S_FRAC_W + 1;          // 24
  localparam int unsigned GRD_POS = WIDE_W - KEEP_W - 1;   // 60
  localparam int unsigned PACK_W  = S_EXP_W + S_FRAC_W;    // 31
  localparam int unsigned SH_W    = 6;
  localparam int unsigned NAN_PL  = S_FRAC_W - 1;          // 22

  logic                  sgn;
  logic [D_EXP_W-1:0]    dexp;
  logic [D_FRAC_W-1:0]   dfrac;
  logic                  is_nan, is_inf, is_zero;
  logic [SIG_W-1:0]      sig;
  logic signed [12:0]    bexp;
  logic signed [12:0]    shs;
  logic                  tiny, huge;
  logic [SH_W-1:0]       sh;
  logic [WIDE_W-1:0]     wide;
  logic [KEEP_W-1:0]     kept;
  logic                  grd, stk, lost;
  logic                  inc;
  logic [PACK_W-1:0]     pack, sum;
  logic                  ovf;
  logic                  to_inf;

  assign sgn   = src[SRC_W-1];
  assign dexp  = src[SRC_W-2 -: D_EXP_W];
  assign dfrac = src[D_FRAC_W-1:0];

  assign is_nan  = (&dexp) && (|dfrac);
  assign is_inf  = (&dexp) && !(|dfrac);
  assign is_zero = !(|dexp) && !(|dfrac);

  // significand with hidden bit; binary64 denormals share the exponent of 1
  assign sig  = {|dexp, dfrac};
  assign bexp = $signed({2'b00, ((|dexp) ? dexp : 11'd1)}) - 13'sd896;
  assign shs  = 13'sd1 - bexp;
  assign tiny = (bexp < 13'sd1);
  assign huge = (bexp > 13'sd254);

  always_comb begin
    if (!tiny)                 sh = '0;
    else if (bexp < -13'sd29)  sh = SH_W'(31);
    else                       sh = shs[SH_W-1:0];
  end

  assign wide = {sig, {PAD_W{1'b0}}} >> sh;
  assign kept = wide[WIDE_W-1 -: KEEP_W];
  assign grd  = wide[GRD_POS];
  assign stk  = |wide[GRD_POS-1:0];
  assign lost = grd | stk;

  always_comb begin
    case (mode)
      RND_NE:  inc = grd & (stk | kept[0]);
      RND_DN:  inc = sgn & lost;
      RND_UP:  inc = ~sgn & lost;
      default: inc = 1'b0;
    endcase
  end

  assign pack = tiny ? {{S_EXP_W{1'b0}}, kept[S_FRAC_W-1:0]}
                     : {bexp[S_EXP_W-1:0], kept[S_FRAC_W-1:0]};
  assign sum  = pack + PACK_W'(inc);
  assign ovf  = huge | (&sum[PACK_W-1 -: S_EXP_W]);

  always_comb begin
    case (mode)
      RND_NE:  to_inf = 1'b1;
      RND_DN:  to_inf = sgn;
      RND_UP:  to_inf = ~sgn;
      default: to_inf = 1'b0;
    endcase
  end

  always_comb begin
    flg = '0;
    if (is_nan) begin
      res         = {sgn, {S_EXP_W{1'b1}}, 1'b1, dfrac[D_FRAC_W-2 -: NAN_PL]};
      flg.invalid = ~dfrac[D_FRAC_W-1];
    end else if (is_inf) begin
      res = {sgn, {S_EXP_W{1'b1}}, {S_FRAC_W{1'b0}}};
    end else if (is_zero) begin
      res = {sgn, {PACK_W{1'b0}}};
    end else if (ovf) begin
      res          = to_inf ? {sgn, {S_EXP_W{1'b1}}, {S_FRAC_W{1'b0}}}
                            : {sgn, {(S_EXP_W-1){1'b1}}, 1'b0, {S_FRAC_W{1'b1}}};
      flg.overflow = 1'b1;
      flg.inexact  = 1'b1;
    end else begin
      res           = {sgn, sum};
      flg.inexact   = lost;
      flg.underflow = tiny & lost;
    end
  end

  // bits lost only ever leave the sum at or above the truncated value
  always_comb begin
    if (!is_nan && !is_inf && !is_zero && !ovf)
      a_round_monotone_r2: assert (sum >= pack);
  end

endmodule

// File: rtl/d2s_lane_merge.sv
module d2s_lane_merge
  import d2s_pkg::*;
#(
  parameter int unsigned VEC_W = 512
) (
  input  logic [RES_W-1:0]  res,
  input  fp_flags_t         flg_in,
  input  logic [VEC_W-1:0]  old_dst,
  input  logic [VEC_W-1:0]  pass_vec,
  input  merge_e            sel,
  input  logic              wmask,
  input  logic              zeroing,
  output logic [VEC_W-1:0]  dst,
  output fp_flags_t         flg_out
);

  localparam int unsigned MID_W = LANE_W - RES_W;
  localparam int unsigned HI_W  = VEC_W - LANE_W;

  logic [RES_W-1:0] lo;
  logic [MID_W-1:0] mid;
  logic             keep_style;

  assign keep_style = (sel == MRG_KEEP);

  always_comb begin
    flg_out = flg_in;
    lo      = res;
    if (sel == MRG_MASK && !wmask) begin
      lo      = zeroing ? '0 : old_dst[RES_W-1:0];
      flg_out = '0;
    end
  end

  assign mid = keep_style ? old_dst[LANE_W-1:RES_W] : pass_vec[LANE_W-1:RES_W];

  generate
    if (VEC_W > LANE_W) begin : g_hi
      logic [HI_W-1:0] hi;
      assign hi  = keep_style ? old_dst[VEC_W-1:LANE_W] : '0;
      assign dst = {hi, mid, lo};
    end else begin : g_nohi
      assign dst = {mid, lo};
    end
  endgenerate

endmodule

// File: rtl/d2s_convert_top.sv
module d2s_convert_top
  import d2s_pkg::*;
#(
  parameter int unsigned VEC_W = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] pass_vec,
  input  logic [VEC_W-1:0] old_dst,
  input  logic [1:0]       rnd_global,
  input  logic             rnd_ovr_en,
  input  logic [1:0]       rnd_ovr,
  input  logic [1:0]       merge_sel,
  input  logic             wmask,
  input  logic             zeroing,
  output logic             out_valid,
  output logic [VEC_W-1:0] dst_out,
  output logic [3:0]       flags
);

  localparam int unsigned FLAG_W = $bits(fp_flags_t);

  merge_e           sel;
  rnd_mode_e        eff_mode;
  logic [RES_W-1:0] conv_res;
  fp_flags_t        conv_flg;
  fp_flags_t        mrg_flg;
  logic [VEC_W-1:0] mrg_dst;

  logic              vld_d, vld_q;
  logic [VEC_W-1:0]  dst_d, dst_q;
  logic [FLAG_W-1:0] flg_d, flg_q;

  assign sel      = merge_e'(merge_sel);
  assign eff_mode = (sel == MRG_MASK && rnd_ovr_en) ? rnd_mode_e'(rnd_ovr)
                                                    : rnd_mode_e'(rnd_global);

  d2s_round_core u_core (
    .src  (src_vec[SRC_W-1:0]),
    .mode (eff_mode),
    .res  (conv_res),
    .flg  (conv_flg)
  );

  d2s_lane_merge #(.VEC_W(VEC_W)) u_merge (
    .res      (conv_res),
    .flg_in   (conv_flg),
    .old_dst  (old_dst),
    .pass_vec (pass_vec),
    .sel      (sel),
    .wmask    (wmask),
    .zeroing  (zeroing),
    .dst      (mrg_dst),
    .flg_out  (mrg_flg)
  );

  // next-state
  always_comb begin
    vld_d = in_valid;
    dst_d = dst_q;
    flg_d = flg_q;
    if (in_valid) begin
      dst_d = mrg_dst;
      flg_d = mrg_flg;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dst_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= vld_d;
      dst_q <= dst_d;
      flg_q <= flg_d;
    end
  end

  assign out_valid = vld_q;
  assign dst_out   = dst_q;
  assign flags     = flg_q;

  // R11: one-cycle valid latency
  p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dst_out) && $stable(flags)));

  // R7: keep style leaves upper destination untouched
  p_keep_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && merge_sel == 2'b00) |=>
      dst_out[VEC_W-1:RES_W] == $past(old_dst[VEC_W-1:RES_W]));

  // R8: copy and masked styles take bits 127:32 from the pass vector
  p_copy_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && merge_sel != 2'b00) |=>
      dst_out[LANE_W-1:RES_W] == $past(pass_vec[LANE_W-1:RES_W]));

  generate
    if (VEC_W > LANE_W) begin : g_hi_chk
      p_zero_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && merge_sel != 2'b00) |=> dst_out[VEC_W-1:LANE_W] == '0);
    end
  endgenerate

  // R9: masked-off element raises no flags and honours zeroing
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && merge_sel == 2'b10 && !wmask) |=> flags == 4'b0000);
  p_masked_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && merge_sel == 2'b10 && !wmask && zeroing) |=> dst_out[RES_W-1:0] == '0);

  // R3 / R4: overflow and underflow always come with inexact
  p_ovf_inexact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[1]) |-> flags[3]);
  p_unf_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[2]) |-> flags[3]);

endmodule

// File: tb/tb_d2s_convert_top.sv
module tb_d2s_convert_top;

  localparam int VW = 512;

  localparam logic [3:0] F_NONE = 4'b0000;
  localparam logic [3:0] F_INV  = 4'b0001;
  localparam logic [3:0] F_OVF  = 4'b0010;
  localparam logic [3:0] F_UNF  = 4'b0100;
  localparam logic [3:0] F_INX  = 4'b1000;

  localparam logic [1:0] NE = 2'b00, DN = 2'b01, UP = 2'b10, TZ = 2'b11;
  localparam logic [1:0] KEEP = 2'b00, COPY = 2'b01, MASK = 2'b10, RSVD = 2'b11;

  localparam logic [VW-1:0] OLD_PAT  = {8{64'hDEAD_BEEF_0123_4567}};
  localparam logic [VW-1:0] PASS_PAT = {8{64'h1357_9BDF_2468_ACE0}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [VW-1:0] src_vec, pass_vec, old_dst;
  logic [1:0]    rnd_global, rnd_ovr, merge_sel;
  logic          rnd_ovr_en, wmask, zeroing;
  logic          out_valid;
  logic [VW-1:0] dst_out;
  logic [3:0]    flags;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  d2s_convert_top #(.VEC_W(VW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_vec(src_vec), .pass_vec(pass_vec), .old_dst(old_dst),
    .rnd_global(rnd_global), .rnd_ovr_en(rnd_ovr_en), .rnd_ovr(rnd_ovr),
    .merge_sel(merge_sel), .wmask(wmask), .zeroing(zeroing),
    .out_valid(out_valid), .dst_out(dst_out), .flags(flags)
  );

  task automatic check(input string req, input logic [VW-1:0] got,
                       input logic [VW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one operation at a falling edge; results are sampled at the next one
  task automatic apply(input logic [63:0] src, input logic [1:0] rg,
                       input logic oe, input logic [1:0] ro,
                       input logic [1:0] sel, input logic wm, input logic zr);
    @(negedge clk);
    src_vec    = {{(VW-64){1'b1}}, src};
    pass_vec   = PASS_PAT;
    old_dst    = OLD_PAT;
    rnd_global = rg;
    rnd_ovr_en = oe;
    rnd_ovr    = ro;
    merge_sel  = sel;
    wmask      = wm;
    zeroing    = zr;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid   = 1'b0;
  endtask

  // conversion in keep style: low element, upper bits and flags
  task automatic conv(input string req, input logic [63:0] src, input logic [1:0] rg,
                      input logic [31:0] exp_res, input logic [3:0] exp_flg);
    apply(src, rg, 1'b0, NE, KEEP, 1'b1, 1'b0);
    check(req, VW'(dst_out[31:0]), VW'(exp_res));
    check(req, VW'(flags), VW'(exp_flg));
  endtask

  task automatic t_reset();
    check("R11 reset valid", VW'(out_valid), '0);
    check("R11 reset data", dst_out, '0);
    check("R11 reset flags", VW'(flags), '0);
  endtask

  task automatic t_exact_r1();
    conv("R1 one",         64'h3FF0_0000_0000_0000, NE, 32'h3F80_0000, F_NONE);
    conv("R1 neg2.5",      64'hC004_0000_0000_0000, TZ, 32'hC020_0000, F_NONE);
    conv("R1 min normal",  64'h3810_0000_0000_0000, NE, 32'h0080_0000, F_NONE);
    conv("R1 max finite",  64'h47EF_FFFF_E000_0000, UP, 32'h7F7F_FFFF, F_NONE);
  endtask

  task automatic t_rounding_r2();
    conv("R2 tie NE",   64'h3FF0_0000_1000_0000, NE, 32'h3F80_0000, F_INX);
    conv("R2 tie UP",   64'h3FF0_0000_1000_0000, UP, 32'h3F80_0001, F_INX);
    conv("R2 tie DN",   64'h3FF0_0000_1000_0000, DN, 32'h3F80_0000, F_INX);
    conv("R2 tie TZ",   64'h3FF0_0000_1000_0000, TZ, 32'h3F80_0000, F_INX);
    conv("R2 odd tie",  64'h3FF0_0000_3000_0000, NE, 32'h3F80_0002, F_INX);
    conv("R2 neg DN",   64'hBFF0_0000_0000_0001, DN, 32'hBF80_0001, F_INX);
    conv("R2 neg UP",   64'hBFF0_0000_0000_0001, UP, 32'hBF80_0000, F_INX);
  endtask

  task automatic t_overflow_r3();
    conv("R3 big NE",     64'h7E37_E43C_8800_759C, NE, 32'h7F80_0000, F_OVF | F_INX);
    conv("R3 big TZ",     64'h7E37_E43C_8800_759C, TZ, 32'h7F7F_FFFF, F_OVF | F_INX);
    conv("R3 neg UP",     64'hFE37_E43C_8800_759C, UP, 32'hFF7F_FFFF, F_OVF | F_INX);
    conv("R3 neg DN",     64'hFE37_E43C_8800_759C, DN, 32'hFF80_0000, F_OVF | F_INX);
    conv("R3 round over", 64'h47EF_FFFF_F000_0000, NE, 32'h7F80_0000, F_OVF | F_INX);
  endtask

  task automatic t_tiny_r4();
    conv("R4 min denorm", 64'h36A0_0000_0000_0000, NE, 32'h0000_0001, F_NONE);
    conv("R4 half NE",    64'h3690_0000_0000_0000, NE, 32'h0000_0000, F_UNF | F_INX);
    conv("R4 half UP",    64'h3690_0000_0000_0000, UP, 32'h0000_0001, F_UNF | F_INX);
    conv("R4 d-denorm NE",64'h0000_0000_0000_0001, NE, 32'h0000_0000, F_UNF | F_INX);
    conv("R4 d-denorm DN",64'h8000_0000_0000_0001, DN, 32'h8000_0001, F_UNF | F_INX);
  endtask

  task automatic t_special_r5_r6();
    conv("R5 qnan",  64'h7FF8_0000_0000_0000, NE, 32'h7FC0_0000, F_NONE);
    conv("R5 snan",  64'hFFF4_0000_0000_0000, TZ, 32'hFFE0_0000, F_INV);
    conv("R6 -zero", 64'h8000_0000_0000_0000, UP, 32'h8000_0000, F_NONE);
    conv("R6 -inf",  64'hFFF0_0000_0000_0000, NE, 32'hFF80_0000, F_NONE);
  endtask

  task automatic t_keep_r7();
    apply(64'h3FF0_0000_0000_0000, NE, 1'b0, NE, KEEP, 1'b0, 1'b1);
    check("R7 keep", dst_out, {OLD_PAT[VW-1:32], 32'h3F80_0000});
  endtask

  task automatic t_copy_r8();
    apply(64'hC004_0000_0000_0000, NE, 1'b0, NE, COPY, 1'b0, 1'b1);
    check("R8 copy", dst_out, {{(VW-128){1'b0}}, PASS_PAT[127:32], 32'hC020_0000});
    apply(64'hC004_0000_0000_0000, NE, 1'b0, NE, RSVD, 1'b1, 1'b0);
    check("R8 reserved", dst_out, {{(VW-128){1'b0}}, PASS_PAT[127:32], 32'hC020_0000});
  endtask

  task automatic t_masked_r9();
    apply(64'h7E37_E43C_8800_759C, NE, 1'b0, NE, MASK, 1'b1, 1'b1);
    check("R9 mask set", dst_out, {{(VW-128){1'b0}}, PASS_PAT[127:32], 32'h7F80_0000});
    check("R9 mask set flags", VW'(flags), VW'(F_OVF | F_INX));
    apply(64'h7E37_E43C_8800_759C, NE, 1'b0, NE, MASK, 1'b0, 1'b0);
    check("R9 merge keep", dst_out, {{(VW-128){1'b0}}, PASS_PAT[127:32], OLD_PAT[31:0]});
    check("R9 merge flags", VW'(flags), '0);
    apply(64'h7FF4_0000_0000_0000, NE, 1'b0, NE, MASK, 1'b0, 1'b1);
    check("R9 zeroing", dst_out, {{(VW-128){1'b0}}, PASS_PAT[127:32], 32'h0});
    check("R9 zeroing flags", VW'(flags), '0);
  endtask

  task automatic t_override_r10();
    apply(64'h3FF0_0000_1000_0000, NE, 1'b1, UP, MASK, 1'b1, 1'b0);
    check("R10 override used", VW'(dst_out[31:0]), VW'(32'h3F80_0001));
    apply(64'h3FF0_0000_1000_0000, NE, 1'b0, UP, MASK, 1'b1, 1'b0);
    check("R10 override off", VW'(dst_out[31:0]), VW'(32'h3F80_0000));
    apply(64'h3FF0_0000_1000_0000, NE, 1'b1, UP, KEEP, 1'b1, 1'b0);
    check("R10 keep ignores", VW'(dst_out[31:0]), VW'(32'h3F80_0000));
    apply(64'h3FF0_0000_1000_0000, UP, 1'b1, TZ, COPY, 1'b1, 1'b0);
    check("R10 copy ignores", VW'(dst_out[31:0]), VW'(32'h3F80_0001));
  endtask

  task automatic t_latency_r11();
    logic [VW-1:0] snap;
    apply(64'hC004_0000_0000_0000, NE, 1'b0, NE, KEEP, 1'b1, 1'b0);
    check("R11 valid high", VW'(out_valid), VW'(1'b1));
    snap = dst_out;
    src_vec = '0;
    old_dst = '1;
    @(negedge clk);
    check("R11 valid low", VW'(out_valid), '0);
    check("R11 hold", dst_out, snap);
  endtask

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    src_vec    = '0;
    pass_vec   = '0;
    old_dst    = '0;
    rnd_global = NE;
    rnd_ovr_en = 1'b0;
    rnd_ovr    = NE;
    merge_sel  = KEEP;
    wmask      = 1'b0;
    zeroing    = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_exact_r1();
    t_rounding_r2();
    t_overflow_r3();
    t_tiny_r4();
    t_special_r5_r6();
    t_keep_r7();
    t_copy_r8();
    t_masked_r9();
    t_override_r10();
    t_latency_r11();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule